// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked core and an external 32K x 8 asynchronous static RAM. The core presents one request at a time: when `ready_o` is high, it may assert `req_i` for a cycle with an address, a direction and (for writes) a byte. The controller then produces the chip-select, output-enable and write-enable waveforms the RAM needs. For a read, it returns the captured byte on `rdata_o` with a single-cycle `rvalid_o` pulse.

All RAM timing minimums are parameters in nanoseconds, together with the clock period. Each minimum is turned into a whole number of clock cycles by rounding up, with a floor of one cycle. A read holds the read strobes long enough to cover the cycle, address-access and output-enable-access times. A write holds write enable low long enough to cover the pulse width and the address-to-end time. The write pulse also covers a release window for the RAM's data drivers followed by the data setup time. The controller drives its own data only during the last setup cycles of the pulse and one hold cycle afterwards. When a write follows a read, idle turnaround cycles give the RAM's outputs time to float first.

The data bus is split into `sram_dq_o`, `sram_dq_i` and `sram_dq_oe_o`, so the pad ring can build the tri-state driver.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_ni` is low, including a reset applied in the middle of an access, `sram_cs_no`, `sram_oe_no` and `sram_we_no` are high, `sram_dq_oe_o` and `rvalid_o` are low, and no request is taken.
- R2: A read holds `sram_cs_no`=0, `sram_oe_no`=0 and `sram_we_no`=1 for RD_CYC consecutive cycles. RD_CYC is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_AOE/CLK), which is 4 at the defaults.
- R3: The byte on `sram_dq_i` in the last read cycle appears on `rdata_o` the next cycle, together with `rvalid_o` high for exactly one cycle. That cycle is RD_CYC+1 cycles after the request cycle.
- R4: A write holds `sram_cs_no`=0, `sram_we_no`=0 and `sram_oe_no`=1 for WR_CYC consecutive cycles. WR_CYC is the largest of ceil(T_WC/CLK), ceil(T_WP/CLK), ceil(T_AW/CLK) and ceil(T_WHZ/CLK)+ceil(T_DW/CLK), which is 4 at the defaults.
- R5: During a write, `sram_dq_oe_o` is high in exactly the last DW_CYC=ceil(T_DW/CLK) cycles of the write-enable pulse (2 at the defaults) and in the one cycle after write enable rises. `sram_dq_o` is stable while it is driven.
- R6: `sram_dq_oe_o` is never high while `sram_oe_no` is low.
- R7: When a write is accepted in the idle cycle right after a read, 1+TA_CYC cycles with both `sram_oe_no` and `sram_we_no` high separate the two. TA_CYC=ceil(T_OHZ/CLK), which is 1 at the defaults.
- R8: `ready_o` is high only when the controller is idle. A `req_i` seen while `ready_o` is low has no effect: it produces no strobe and writes no data.
- R9: Between accesses all three strobes are high and `sram_dq_oe_o` is low. A write without turnaround returns `ready_o` high WR_CYC+2 cycles after its request cycle.
- R10: `sram_addr_o` equals the accepted address and does not change while `sram_cs_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Controller idle, request may be taken |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| rdata_o | output | 8 | Captured read byte |
| sram_addr_o | output | 15 | RAM address bus |
| sram_dq_o | output | 8 | RAM data bus, outbound |
| sram_dq_i | input | 8 | RAM data bus, inbound |
| sram_dq_oe_o | output | 1 | Enable for the outbound data driver |
| sram_cs_no | output | 1 | RAM chip select, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |

## Verification
Several properties are checked every cycle:
- write enable and output enable are never low together;
- the controller's data driver is off whenever output enable is low;
- the address and the driven write byte do not move mid-access;
- `rvalid_o` never lasts two cycles;
- write enable stays high in the two cycles after output enable was low.

The exact pulse lengths, the placement of the data-drive window inside the write pulse, the turnaround gap, the read latency and the returned byte are shown by the bench scenarios. The same holds for requests ignored while busy and for the effect of a reset in mid-write. Those scenarios run against a byte-wide memory model that commits data on the rising edge of write enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WR,
    ST_HOLD
  } ctrl_state_e;

  // ceiling of ns/period, never below one cycle
  function automatic int ns2cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 4,
  parameter int WR_CYC = 4,
  parameter int DW_CYC = 2,
  parameter int TA_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_we_i,
  output logic idle_o,
  output logic cs_no,
  output logic oe_no,
  output logic we_no,
  output logic dq_oe_o,
  output logic cap_o
);

  localparam int MAX_CYC = max2(max2(RD_CYC, WR_CYC), TA_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic rd_last_q;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rd_last_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (!start_we_i) begin
            state_q <= ST_RD;
            cnt_q   <= CNT_W'(RD_CYC - 1);
          end else if (rd_last_q) begin
            state_q <= ST_TURN;
            cnt_q   <= CNT_W'(TA_CYC - 1);
          end else begin
            state_q <= ST_WR;
            cnt_q   <= CNT_W'(WR_CYC - 1);
          end
        end
        ST_TURN: begin
          if (cnt_zero) begin
            state_q <= ST_WR;
            cnt_q   <= CNT_W'(WR_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_RD: begin
          if (cnt_zero) begin
            state_q   <= ST_IDLE;
            rd_last_q <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_WR: begin
          rd_last_q <= 1'b0;
          if (cnt_zero) state_q <= ST_HOLD;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_HOLD: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign cs_no   = !((state_q == ST_RD) || (state_q == ST_WR));
  assign oe_no   = (state_q != ST_RD);
  assign we_no   = (state_q != ST_WR);
  // drive only in the setup window at the end of the pulse, plus one hold cycle
  assign dq_oe_o = ((state_q == ST_WR) && (cnt_q < CNT_W'(DW_CYC))) ||
                   (state_q == ST_HOLD);
  assign cap_o   = (state_q == ST_RD) && cnt_zero;

  // R6
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_no);

  // R4
  wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (oe_no && !cs_no));

  // R7
  turn_gap1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!oe_no) |-> we_no);

  // R7
  turn_gap2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!oe_no, 2) |-> we_no);

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (start_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

  // R3
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_AOE_NS  = 30,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 50,
  parameter int T_AW_NS   = 70,
  parameter int T_DW_NS   = 30,
  parameter int T_WHZ_NS  = 25,
  parameter int T_OHZ_NS  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o,
  output logic              sram_cs_no,
  output logic              sram_oe_no,
  output logic              sram_we_no
);

  localparam int RD_CYC = max2(max2(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                               ns2cyc(T_AOE_NS, CLK_NS));
  localparam int DW_CYC = ns2cyc(T_DW_NS, CLK_NS);
  localparam int WR_CYC = max2(max2(ns2cyc(T_WC_NS, CLK_NS), ns2cyc(T_WP_NS, CLK_NS)),
                               max2(ns2cyc(T_AW_NS, CLK_NS),
                                    ns2cyc(T_WHZ_NS, CLK_NS) + DW_CYC));
  localparam int TA_CYC = ns2cyc(T_OHZ_NS, CLK_NS);

  logic start, cap;

  assign start = req_i && ready_o;

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC),
    .WR_CYC(WR_CYC),
    .DW_CYC(DW_CYC),
    .TA_CYC(TA_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .start_we_i(we_i),
    .idle_o    (ready_o),
    .cs_no     (sram_cs_no),
    .oe_no     (sram_oe_no),
    .we_no     (sram_we_no),
    .dq_oe_o   (sram_dq_oe_o),
    .cap_o     (cap)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cap_i   (cap),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .dq_i    (sram_dq_i),
    .addr_o  (sram_addr_o),
    .wdata_o (sram_dq_o),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  // R10
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_addr_o));

  // R5
  wdata_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  // R8
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_cs_no && sram_we_no && sram_oe_no));

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int RD_EXP = 4;
  localparam int WR_EXP = 4;
  localparam int DW_EXP = 2;
  localparam int TA_EXP = 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, rvalid_o, sram_dq_oe_o, sram_cs_no, sram_oe_no, sram_we_no;
  logic [7:0]  rdata_o, sram_dq_o, sram_dq_i;
  logic [14:0] sram_addr_o;

  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  sram_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o),
    .rvalid_o(rvalid_o), .rdata_o(rdata_o), .sram_addr_o(sram_addr_o),
    .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i), .sram_dq_oe_o(sram_dq_oe_o),
    .sram_cs_no(sram_cs_no), .sram_oe_no(sram_oe_no), .sram_we_no(sram_we_no)
  );

  // memory model
  logic [7:0] mem [logic [14:0]];

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  assign sram_dq_i = (!sram_cs_no && !sram_oe_no && sram_we_no) ? mem_rd(sram_addr_o) : 8'h5A;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor state
  logic        p_we = 1'b1, p_oe = 1'b1, p_cs = 1'b1, p_dqoe = 1'b0;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int we_run = 0, dq_run = 0, oe_run = 0, since_rd = 0, last_gap = -1, we_pulses = 0;
  bit rd_seen = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_we = 1'b1; p_oe = 1'b1; p_cs = 1'b1; p_dqoe = 1'b0;
      we_run = 0; dq_run = 0; oe_run = 0; rd_seen = 0;
    end else begin
      if (!sram_cs_no && !p_cs && sram_addr_o !== p_addr)
        chk(0, "R10", "address moved", int'(sram_addr_o), int'(p_addr));
      if (sram_dq_oe_o && !sram_oe_no)
        chk(0, "R6", "driver on while oe low", 1, 0);
      if (!sram_we_no) begin
        if (p_we && rd_seen) begin
          last_gap = since_rd;
          rd_seen = 0;
        end
        we_run++;
        if (sram_dq_oe_o) dq_run++;
      end else if (!p_we) begin
        chk(we_run == WR_EXP, "R4", "we pulse length", we_run, WR_EXP);
        chk(dq_run == DW_EXP, "R5", "drive cycles in pulse", dq_run, DW_EXP);
        chk(sram_dq_oe_o && sram_dq_o === p_dq, "R5", "hold cycle data",
            int'(sram_dq_o), int'(p_dq));
        if (p_dqoe) mem[p_addr] = p_dq;
        we_pulses++;
        we_run = 0;
        dq_run = 0;
      end
      if (!sram_oe_no) oe_run++;
      else if (!p_oe) begin
        chk(oe_run == RD_EXP, "R2", "oe pulse length", oe_run, RD_EXP);
        oe_run = 0;
        since_rd = 0;
        rd_seen = 1;
      end
      if (sram_oe_no && sram_we_no) since_rd++;
      p_we = sram_we_no; p_oe = sram_oe_no; p_cs = sram_cs_no;
      p_dqoe = sram_dq_oe_o; p_addr = sram_addr_o; p_dq = sram_dq_o;
    end
  end

  task automatic wait_ready();
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input int exp_cyc);
    int cyc;
    wait_ready();
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0;
    cyc = 1;
    while (!ready_o) begin @(negedge clk_i); cyc++; end
    chk(cyc == exp_cyc, "R9", "write busy cycles", cyc, exp_cyc);
    chk(sram_cs_no && sram_oe_no && sram_we_no && !sram_dq_oe_o, "R9",
        "idle strobes", {sram_cs_no, sram_oe_no, sram_we_no, sram_dq_oe_o}, 4'b1110);
  endtask

  task automatic do_read(input logic [14:0] a, input logic [7:0] exp);
    int cyc;
    wait_ready();
    req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0;
    addr_i = ~a;
    chk(sram_addr_o == a, "R10", "read address", int'(sram_addr_o), int'(a));
    chk(!sram_cs_no && !sram_oe_no && sram_we_no, "R2", "read strobes",
        {sram_cs_no, sram_oe_no, sram_we_no}, 3'b001);
    cyc = 1;
    while (!rvalid_o && cyc < 20) begin @(negedge clk_i); cyc++; end
    chk(cyc == RD_EXP + 1, "R3", "read latency", cyc, RD_EXP + 1);
    chk(rdata_o == exp, "R3", "read data", int'(rdata_o), int'(exp));
    @(negedge clk_i);
    chk(!rvalid_o, "R3", "rvalid single pulse", int'(rvalid_o), 0);
  endtask

  task automatic test_reset();
    chk(sram_cs_no && sram_oe_no && sram_we_no, "R1", "strobes in reset",
        {sram_cs_no, sram_oe_no, sram_we_no}, 3'b111);
    chk(!sram_dq_oe_o && !rvalid_o, "R1", "drive/valid in reset",
        {sram_dq_oe_o, rvalid_o}, 0);
  endtask

  task automatic test_basic();
    do_write(15'h0000, 8'h3C, WR_EXP + 2);
    do_write(15'h7FFF, 8'hC3, WR_EXP + 2);
    do_write(15'h1234, 8'h77, WR_EXP + 2);
    do_read(15'h0000, 8'h3C);
    do_read(15'h7FFF, 8'hC3);
    do_read(15'h1234, 8'h77);
  endtask

  task automatic test_rd_then_wr();
    wait_ready();
    req_i = 1; we_i = 0; addr_i = 15'h7FFF;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1; addr_i = 15'h2222; wdata_i = 8'h9D;
    while (!ready_o) @(negedge clk_i);
    chk(rvalid_o && rdata_o == 8'hC3, "R3", "read data before write", int'(rdata_o), 8'hC3);
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0;
    while (!ready_o) @(negedge clk_i);
    chk(last_gap == TA_EXP + 1, "R7", "read-to-write gap", last_gap, TA_EXP + 1);
    do_read(15'h2222, 8'h9D);
  endtask

  task automatic test_busy_ignored();
    int pulses0;
    pulses0 = we_pulses;
    wait_ready();
    req_i = 1; we_i = 1; addr_i = 15'h4000; wdata_i = 8'h11;
    @(posedge clk_i);
    @(negedge clk_i);
    addr_i = 15'h1234; wdata_i = 8'hEE;
    chk(!ready_o, "R8", "ready low while busy", int'(ready_o), 0);
    repeat (3) @(negedge clk_i);
    req_i = 0;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    chk(we_pulses == pulses0 + 1, "R8", "write pulses", we_pulses, pulses0 + 1);
    do_read(15'h1234, 8'h77);
    do_read(15'h4000, 8'h11);
  endtask

  task automatic test_reset_midwrite();
    wait_ready();
    req_i = 1; we_i = 1; addr_i = 15'h0055; wdata_i = 8'hAB;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0;
    @(negedge clk_i);
    rst_ni = 0;
    #1;
    chk(sram_cs_no && sram_oe_no && sram_we_no && !sram_dq_oe_o, "R1",
        "strobes after mid-write reset",
        {sram_cs_no, sram_oe_no, sram_we_no, sram_dq_oe_o}, 4'b1110);
    req_i = 1; we_i = 1;
    repeat (3) @(negedge clk_i);
    chk(sram_we_no && sram_cs_no, "R1", "request held off in reset",
        {sram_we_no, sram_cs_no}, 2'b11);
    req_i = 0;
    rst_ni = 1;
    do_read(15'h0055, 8'h00);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1;
    test_basic();
    test_rd_then_wr();
    test_busy_ignored();
    test_reset_midwrite();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        chk(0, "WDOG", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule